// File: doc/BRIEF.md
# Trigger-Controlled Sleep and Wake Manager

This block decides when the synchronous-rectifier control logic goes into a low-power sleep state and when it may drive again. It has two inputs: a synchronised trigger/disable level and the drain-sense turn-on flag. A trigger that is held high for a long, unbroken stretch puts the block to sleep. A trigger that drops during sleep starts a wake sequence. The block gives the gate control state machine a sleep indicator and a driver-enable qualifier.

Wake-up has two stages. First a fixed recovery delay runs while the driver stays disabled. After that the block waits for a fresh rising edge of the drain-sense turn-on flag, so the driver is released at the start of a new switching cycle and never partway through one. Both durations are parameters counted in clock cycles: `SLEEP_CYC` for the sleep timeout and `WAKE_CYC` for the recovery time. The sleep timer measures the trigger level and not its edges. A trigger rise that comes while the gate logic is blanking its trigger path therefore still starts the timeout.

The controller has four states. In the active state the driver may be enabled. In the sleep state the sleep indicator is high. In the recovering state the recovery delay runs. In the armed state the block waits for a drain-sense edge.

Top module: `trig_sleep_mgr`

## Requirements
- R1: While reset is low (asynchronous), and after it is released, the block is in the active state with `sleep_o` = 0 and `drv_en_o` equal to the inverse of `trig_i`.
- R2: In the active state, `drv_en_o` is 1 exactly when `trig_i` is 0, in the same cycle without a register delay.
- R3: `sleep_o` rises after the clock edge at which `trig_i` has been sampled high on `SLEEP_CYC` consecutive edges in the active state, and not earlier.
- R4: Any edge that samples `trig_i` low in the active state restarts the sleep timer from zero.
- R5: `drv_en_o` is 0 throughout the trigger-high approach to sleep and for as long as `sleep_o` is 1. Sleep lasts while `trig_i` stays high.
- R6: An edge that samples `trig_i` low during sleep starts recovery. `sleep_o` falls after that edge. Recovery lasts `WAKE_CYC` further edges with `trig_i` low, and `drv_en_o` stays 0 during it.
- R7: If `trig_i` is sampled high during recovery or while waiting for a drain-sense edge, the block returns to sleep at that edge.
- R8: After recovery, the block returns to the active state only at an edge that samples `sense_i` high when the previous edge sampled it low. A sense rise sampled during recovery does not count, and neither does a level that is already high. `drv_en_o` goes high after that edge.
- R9: The sleep timer counts the trigger level regardless of activity on `sense_i`. A trigger rise during switching noise still reaches sleep after exactly `SLEEP_CYC` high samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Synchronised trigger/disable level, high = disable request |
| sense_i | input | 1 | Drain-sense turn-on flag, synchronised |
| sleep_o | output | 1 | High while in the sleep state |
| drv_en_o | output | 1 | Driver-enable qualifier to the gate control state machine |

## Verification
The bench builds the block with `SLEEP_CYC` = 20 and `WAKE_CYC` = 8 instead of the 100 ms and 10 ms defaults. At these values the exact sleep-entry edge, a trigger that drops one cycle before the timeout, and the last recovery cycle can all be checked one cycle at a time. The short recovery also lets the bench place a drain-sense rise just before and just after recovery ends. It can return the trigger high from both wake stages and toggle the sense flag during the sleep countdown, all within a short run.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_RECOVER = 2'd2,
    ST_ARM     = 2'd3
  } tsm_state_e;
endpackage

// File: rtl/tsm_cycle_timer.sv
module tsm_cycle_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign done_o = run_i && at_end;

  // dropping run clears the count: continuous-run measurement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || at_end)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsm_rise_det.sv
module tsm_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i && !sig_q;
endmodule

// File: rtl/tsm_ctrl_fsm.sv
module tsm_ctrl_fsm
  import tsm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       sense_rise_i,
  input  logic       sleep_done_i,
  input  logic       wake_done_i,
  output tsm_state_e state_o,
  output logic       sleep_run_o,
  output logic       wake_run_o
);
  tsm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (sleep_done_i) state_d = ST_SLEEP;
      ST_SLEEP:   if (!trig_i)      state_d = ST_RECOVER;
      ST_RECOVER: begin
        if (trig_i)           state_d = ST_SLEEP;
        else if (wake_done_i) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (trig_i)            state_d = ST_SLEEP;
        else if (sense_rise_i) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign sleep_run_o = (state_q == ST_ACTIVE) && trig_i;
  assign wake_run_o  = (state_q == ST_RECOVER) && !trig_i;
endmodule

// File: rtl/trig_sleep_mgr.sv
module trig_sleep_mgr
  import tsm_pkg::*;
#(
  parameter int unsigned SLEEP_CYC = 10_000_000,
  parameter int unsigned WAKE_CYC  = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic sense_i,
  output logic sleep_o,
  output logic drv_en_o
);
  tsm_state_e state;
  logic sleep_run, wake_run, sleep_done, wake_done, sense_rise;

  tsm_cycle_timer #(.LIMIT(SLEEP_CYC)) u_sleep_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(sleep_run), .done_o(sleep_done)
  );

  tsm_cycle_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(wake_run), .done_o(wake_done)
  );

  tsm_rise_det u_sense_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sense_i), .rise_o(sense_rise)
  );

  tsm_ctrl_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .sense_rise_i(sense_rise),
    .sleep_done_i(sleep_done),
    .wake_done_i (wake_done),
    .state_o     (state),
    .sleep_run_o (sleep_run),
    .wake_run_o  (wake_run)
  );

  assign sleep_o  = (state == ST_SLEEP);
  assign drv_en_o = (state == ST_ACTIVE) && !trig_i;
endmodule

// File: rtl/trig_sleep_mgr_chk.sv
module trig_sleep_mgr_chk
  import tsm_pkg::*;
#(
  parameter int unsigned SLEEP_CYC = 10_000_000,
  localparam int unsigned HW = $clog2(SLEEP_CYC + 2) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       sense_i,
  input  logic       sleep_o,
  input  logic       drv_en_o,
  input  tsm_state_e state_i
);
  // independent run-length of trigger-high samples in the active state
  logic [HW-1:0] high_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) high_run_q <= '0;
    else if (state_i == ST_ACTIVE && trig_i) begin
      if (high_run_q != '1) high_run_q <= high_run_q + 1'b1;
    end else high_run_q <= '0;
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!sleep_o && drv_en_o == !trig_i));

  assert_trig_blocks_drv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> !drv_en_o);

  assert_sleep_entry_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sleep_o) && $past(state_i) == ST_ACTIVE) |-> (high_run_q == HW'(SLEEP_CYC)));

  assert_drv_low_sleep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !drv_en_o);

  assert_sleep_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && trig_i) |=> sleep_o);

  assert_sleep_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !trig_i) |=> (!sleep_o && !drv_en_o));

  assert_wake_retrig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_RECOVER || state_i == ST_ARM) && trig_i) |=> sleep_o);

  assert_arm_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARM && !trig_i) |=>
      ((state_i == ST_ACTIVE) == ($past(sense_i) && !$past(sense_i, 2))));
endmodule

bind trig_sleep_mgr trig_sleep_mgr_chk #(.SLEEP_CYC(SLEEP_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .sense_i (sense_i),
  .sleep_o (sleep_o),
  .drv_en_o(drv_en_o),
  .state_i (state)
);

// File: tb/trig_sleep_mgr_tb.sv
module trig_sleep_mgr_tb;
  localparam int unsigned SLEEP_CYC = 20;
  localparam int unsigned WAKE_CYC  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trig = 1'b0;
  logic sense = 1'b0;
  logic sleep_o, drv_en_o;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk_i = ~clk_i;

  trig_sleep_mgr #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .sense_i(sense),
    .sleep_o(sleep_o), .drv_en_o(drv_en_o)
  );

  // [15:8] cycles, [7:4] requirement, [3] trig, [2] sense, [1] exp sleep, [0] exp drv_en
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    16'h0321,  // R2 active, trigger low
    16'h0558,  // R5 approach, driver held off
    16'h0241,  // R4 trigger drop restarts timer
    16'h1348,  // R4 one sample short of timeout
    16'h013A,  // R3 timeout edge enters sleep
    16'h0A5A,  // R5 sleep holds
    16'h0160,  // R6 release starts recovery
    16'h0760,  // R6 still recovering
    16'h0184,  // R8 sense rise sampled during recovery is ignored
    16'h0384,  // R8 level already high does not count
    16'h0280,  // R8 sense low
    16'h0185,  // R8 fresh rise releases driver
    16'h0221   // R2 back to normal
  };

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1", "sleep_o in reset", sleep_o, 1'b0);
    check("R1", "drv_en_o in reset", drv_en_o, 1'b1);
    rst_ni = 1'b1;
    tick(1);
    check("R1", "sleep_o after reset", sleep_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      trig  = VEC[i][3];
      sense = VEC[i][2];
      tick(int'(VEC[i][15:8]));
      check($sformatf("R%0d", VEC[i][7:4]), $sformatf("vec %0d sleep_o", i), sleep_o, VEC[i][1]);
      check($sformatf("R%0d", VEC[i][7:4]), $sformatf("vec %0d drv_en_o", i), drv_en_o, VEC[i][0]);
    end

    // R2 same-cycle gating by trigger
    trig = 1'b1; #1;
    check("R2", "drv_en_o falls with trigger", drv_en_o, 1'b0);
    trig = 1'b0; #1;
    check("R2", "drv_en_o returns", drv_en_o, 1'b1);
    sense = 1'b0;

    // R7 retrigger during recovery
    trig = 1'b1; tick(SLEEP_CYC);
    check("R3", "sleep after full timeout", sleep_o, 1'b1);
    trig = 1'b0; tick(3);
    check("R6", "recovering", sleep_o, 1'b0);
    check("R6", "drv off in recovery", drv_en_o, 1'b0);
    trig = 1'b1; tick(1);
    check("R7", "retrigger in recovery", sleep_o, 1'b1);
    // R7 retrigger while armed
    trig = 1'b0; tick(1 + WAKE_CYC);
    check("R8", "armed, no edge yet", drv_en_o, 1'b0);
    trig = 1'b1; tick(1);
    check("R7", "retrigger while armed", sleep_o, 1'b1);
    trig = 1'b0; tick(1 + WAKE_CYC);
    check("R6", "recovery complete, still off", drv_en_o, 1'b0);
    sense = 1'b1; tick(1);
    check("R8", "edge after recovery enables", drv_en_o, 1'b1);
    sense = 1'b0; tick(1);

    // R9 timer counts trigger level with sense toggling
    trig = 1'b1;
    for (int k = 0; k < int'(SLEEP_CYC) - 1; k++) begin
      sense = ~sense;
      tick(1);
    end
    check("R9", "no sleep one sample early", sleep_o, 1'b0);
    sense = ~sense; tick(1);
    check("R9", "sleep at exact count under noise", sleep_o, 1'b1);

    // R1 asynchronous reset while asleep
    #1 rst_ni = 1'b0; #1;
    check("R1", "async reset clears sleep", sleep_o, 1'b0);
    check("R1", "drv off while trig high", drv_en_o, 1'b0);
    trig = 1'b0; #1;
    check("R1", "drv follows trig in reset", drv_en_o, 1'b1);
    tick(1);
    rst_ni = 1'b1;
    tick(2);
    check("R2", "active after reset", drv_en_o, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule